// File: doc/BRIEF.md
# Non-Pipelined Bus Cycle Sequencer

This block sits on the processor side of a synchronous external bus and runs bus cycles for internal transfer requests. Each request carries an address, a 32-bit write word, a direction and four byte enables. The sequencer moves through four states: idle, address clock, data clock and hold. It drives the address, an address strobe, the write data with its direction, and a hold acknowledge. It samples a ready input to end each cycle and a narrow-bus input that reports a 16-bit data path. Address pipelining is not supported.

A cycle always takes one address clock followed by one or more data clocks. The data clock repeats as a wait state until ready is sampled high. On a 16-bit bus a transfer that touches the upper byte pair takes a second cycle, which the sequencer runs before it answers any hold request. When a transfer finishes, the sequencer returns the assembled read word one clock later.

Top module: `npbus_seq`

## Requirements
- R1: With `rst_n` low at a rising edge, the sequencer enters idle. `bus_strobe`, `bus_wr`, `hold_ack` and `rsp_valid` go low, and `bus_addr`, `bus_be` and `bus_wdata` go to zero.
- R2: In idle with `hold_req` low and `req_valid` high, `req_take` is high in that same cycle. The next cycle is an address clock: `bus_strobe` is high and `bus_addr`, `bus_be`, `bus_wr` drive the request. `bus_wdata` drives the request word for writes and zero for reads.
- R3: An address clock lasts one cycle and is always followed by a data clock. In the data clock `bus_strobe` is low and the address is unchanged.
- R4: A data clock in which `bus_rdy` is low repeats. Address, byte enables and write data stay stable.
- R5: When `bus_rdy` is high in a data clock and no second half is due, the next state is as follows. It is hold if `hold_req` is high. Otherwise it is a new address clock if `req_valid` is high, with `req_take` high in the data clock. Otherwise it is idle.
- R6: `hold_ack` is high only in the hold state. While it is high, `bus_strobe` is low and address, byte enables and write data are zero.
- R7: In idle, `hold_req` high takes priority over a pending request: the next state is hold and `req_take` stays low.
- R8: The hold state persists while `hold_req` is high, and `req_take` stays low. On the first edge with `hold_req` low, the sequencer goes to an address clock if `req_valid` is high, otherwise to idle.
- R9: A second half is due when `bus_rdy` and `bus_narrow` are both high in the first data clock of a transfer and byte enable bits 3:2 are not both zero. It runs as a new address clock even if `hold_req` is high. In it, the address is the request address plus 2, the byte enables are {be[3:2], 2'b00}, and for writes `bus_wdata` is {16'h0000, wdata[31:16]}.
- R10: `rsp_valid` pulses for one cycle on the clock after the final ready. `rsp_rdata` is then {second-half bus_rdata[15:0], first-half bus_rdata[15:0]} for a split transfer, and the full `bus_rdata` otherwise.
- R11: `bus_rdy` and `bus_narrow` are ignored outside data clocks. Ready high during an address clock does not end the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Internal transfer request pending |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Request write word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Request byte enables |
| req_take | output | 1 | Request accepted at the coming edge |
| bus_rdy | input | 1 | Cycle acknowledge, sampled in data clocks |
| bus_narrow | input | 1 | Bus reports 16-bit width, sampled with ready |
| bus_rdata | input | 32 | Read data from the bus |
| hold_req | input | 1 | External request for the bus |
| bus_addr | output | 32 | Bus address |
| bus_strobe | output | 1 | Address strobe, high in address clocks |
| bus_wr | output | 1 | Cycle direction, high for writes |
| bus_wdata | output | 32 | Write data driven onto the bus |
| bus_be | output | 4 | Bus byte enables |
| hold_ack | output | 1 | Bus released to the external master |
| rsp_valid | output | 1 | Transfer complete, one-cycle pulse |
| rsp_rdata | output | 32 | Assembled read word |

## Verification
The properties assume that `bus_narrow` is meaningful only in the clock where `bus_rdy` is high. They also assume that `hold_req` and `req_valid` change only between edges and never depend on the same cycle's outputs. The stimulus drives every input on the falling edge. It presents the narrow flag together with ready, and it raises a request or hold only when the expected state is known. Ready is pulsed during address clocks on purpose, to show that it is ignored there.

// File: rtl/npbus_pkg.sv
// Shared types for the non-pipelined bus sequencer.
package npbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } bus_st_t;
endpackage

// File: rtl/npbus_fsm.sv
// State register and next-state choice for the bus sequencer.
// Assumes 'more' is valid only in ST_DATA and stable within the cycle.
module npbus_fsm
    import npbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    hold_req,
    input  logic    bus_rdy,
    input  logic    more,
    output bus_st_t st,
    output logic    take_new,
    output logic    take_second
);
    bus_st_t nxt;

    // Choose the following state and which kind of address clock comes next.
    always_comb begin
        nxt         = st;
        take_new    = 1'b0;
        take_second = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (hold_req) begin
                    nxt = ST_HOLD;
                end else if (req_valid) begin
                    nxt      = ST_ADDR;
                    take_new = 1'b1;
                end
            end
            ST_ADDR: nxt = ST_DATA;
            ST_DATA: begin
                if (bus_rdy) begin
                    if (more) begin
                        nxt         = ST_ADDR;
                        take_second = 1'b1;
                    end else if (hold_req) begin
                        nxt = ST_HOLD;
                    end else if (req_valid) begin
                        nxt      = ST_ADDR;
                        take_new = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (!hold_req) begin
                    if (req_valid) begin
                        nxt      = ST_ADDR;
                        take_new = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Hold the current bus state.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end
endmodule

// File: rtl/npbus_xfer.sv
// Latches the accepted request, tracks the split half, and drives the bus
// outputs from the state. Assumes bus_narrow is meaningful only with bus_rdy.
module npbus_xfer
    import npbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_st_t             st,
    input  logic                take_new,
    input  logic                take_second,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_write,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic                bus_narrow,
    output logic                more,
    output logic                half,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_strobe,
    output logic                bus_wr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W/8-1:0] bus_be
);
    localparam int HW    = DATA_W / 2;
    localparam int BEW   = DATA_W / 8;
    localparam int HBEW  = BEW / 2;
    localparam int HSTEP = HW / 8;

    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_wr;
    logic [BEW-1:0]    lat_be;
    logic              active;

    // Capture a new request and mark which half of a split is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            lat_be    <= '0;
            half      <= 1'b0;
        end else if (take_new) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_wr    <= req_write;
            lat_be    <= req_be;
            half      <= 1'b0;
        end else if (take_second) begin
            half      <= 1'b1;
        end
    end

    // A second cycle is due on a narrow bus when the upper lanes are enabled.
    always_comb begin
        more = (st == ST_DATA) && !half && bus_narrow && (lat_be[BEW-1:HBEW] != '0);
    end

    // Drive address, strobe, direction, data and enables from the state.
    always_comb begin
        active     = (st == ST_ADDR) || (st == ST_DATA);
        bus_strobe = (st == ST_ADDR);
        bus_wr     = active && lat_wr;
        bus_addr   = '0;
        bus_be     = '0;
        bus_wdata  = '0;
        if (active) begin
            bus_addr = half ? (lat_addr + ADDR_W'(HSTEP)) : lat_addr;
            bus_be   = half ? {lat_be[BEW-1:HBEW], {HBEW{1'b0}}} : lat_be;
            if (lat_wr) begin
                bus_wdata = half ? {{HW{1'b0}}, lat_wdata[DATA_W-1:HW]} : lat_wdata;
            end
        end
    end
endmodule

// File: rtl/npbus_rdasm.sv
// Assembles read data across split halves and flags transfer completion.
// Assumes bus_rdata is valid in the data clock where bus_rdy is high.
module npbus_rdasm
    import npbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_st_t           st,
    input  logic              bus_rdy,
    input  logic              more,
    input  logic              half,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int HW = DATA_W / 2;

    logic [HW-1:0] lo_keep;
    logic          done;

    // The final ready of a transfer.
    always_comb begin
        done = (st == ST_DATA) && bus_rdy && !more;
    end

    // Keep the first half and present the whole word after the final ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_keep   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (st == ST_DATA && bus_rdy && more) lo_keep <= bus_rdata[HW-1:0];
            if (done) rsp_rdata <= half ? {bus_rdata[HW-1:0], lo_keep} : bus_rdata;
        end
    end
endmodule

// File: rtl/npbus_seq.sv
// Top of the non-pipelined bus sequencer: state control, request latch and
// output drive, and read assembly. Assumes inputs are synchronous to clk.
module npbus_seq
    import npbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_write,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                req_take,
    input  logic                bus_rdy,
    input  logic                bus_narrow,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                hold_req,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_strobe,
    output logic                bus_wr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W/8-1:0] bus_be,
    output logic                hold_ack,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata
);
    bus_st_t st;
    logic    take_new;
    logic    take_second;
    logic    more;
    logic    half;

    npbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_req(hold_req),
        .bus_rdy(bus_rdy), .more(more), .st(st),
        .take_new(take_new), .take_second(take_second)
    );

    npbus_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .st(st), .take_new(take_new),
        .take_second(take_second), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_be(req_be), .bus_narrow(bus_narrow),
        .more(more), .half(half), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_be(bus_be)
    );

    npbus_rdasm #(.DATA_W(DATA_W)) u_rdasm (
        .clk(clk), .rst_n(rst_n), .st(st), .bus_rdy(bus_rdy), .more(more),
        .half(half), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // Report acceptance and hold grant.
    always_comb begin
        req_take = take_new;
        hold_ack = (st == ST_HOLD);
    end
endmodule

// File: rtl/npbus_chk.sv
// Protocol checker for npbus_seq, attached with bind below.
module npbus_chk
    import npbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input bus_st_t             st,
    input logic                half,
    input logic                bus_rdy,
    input logic                bus_narrow,
    input logic                hold_req,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_strobe,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W/8-1:0] bus_be,
    input logic                hold_ack
);
    localparam int BEW  = DATA_W / 8;
    localparam int HBEW = BEW / 2;

    a_r3_addr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (!bus_strobe && $stable(bus_addr)));

    a_r4_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && !bus_rdy) |=>
        (st == ST_DATA && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

    a_r5_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && bus_rdy && half && hold_req) |=> hold_ack);

    a_r6_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!bus_strobe && bus_addr == '0 && bus_be == '0 && bus_wdata == '0));

    a_r7_idle_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && hold_req) |=> hold_ack);

    a_r8_leave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ack && !hold_req) |=> !hold_ack);

    a_r9_split_before_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && bus_rdy && bus_narrow && !half && bus_be[BEW-1:HBEW] != '0)
        |=> (bus_strobe && !hold_ack && half));
endmodule

bind npbus_seq npbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .half(half), .bus_rdy(bus_rdy),
    .bus_narrow(bus_narrow), .hold_req(hold_req), .bus_addr(bus_addr),
    .bus_strobe(bus_strobe), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .hold_ack(hold_ack)
);

// File: tb/npbus_seq_bench.sv
// Scoreboard bench: driver tasks push expected read words, a monitor pops them.
module npbus_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_be = '0;
    logic        req_take;
    logic        bus_rdy = 1'b0;
    logic        bus_narrow = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        hold_req = 1'b0;
    logic [31:0] bus_addr;
    logic        bus_strobe;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic        hold_ack;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    npbus_seq u_npbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_be(req_be),
        .req_take(req_take), .bus_rdy(bus_rdy), .bus_narrow(bus_narrow),
        .bus_rdata(bus_rdata), .hold_req(hold_req), .bus_addr(bus_addr),
        .bus_strobe(bus_strobe), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .hold_ack(hold_ack), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: compare each completion with the oldest expected word (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R10 read word", rsp_rdata, e);
            end
        end
    end

    // Put a request on the inputs.
    task automatic put_req(input logic [31:0] a, input logic [31:0] wd, input logic w, input logic [3:0] be);
        req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = w; req_be = be;
    endtask

    // One transfer starting from idle, ending back in idle.
    task automatic xfer(input logic [31:0] a, input logic [31:0] wd, input logic w,
                        input logic [3:0] be, input int waits, input logic nar,
                        input logic [31:0] rd1, input logic [31:0] rd2);
        bit split;
        split = nar && (be[3:2] != 2'b00);
        put_req(a, wd, w, be);
        #1;
        chk(req_take == 1'b1, "R2 take from idle", 32'(req_take), 32'h1);
        exp_q.push_back(split ? {rd2[15:0], rd1[15:0]} : rd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_strobe && bus_addr == a && bus_be == be && bus_wr == w, "R2 address clock", bus_addr, a);
        chk(bus_wdata == (w ? wd : 32'h0), "R2 write data", bus_wdata, w ? wd : 32'h0);
        bus_rdy = 1'b1; bus_narrow = nar;           // ignored in the address clock (R11)
        @(negedge clk);
        chk(!bus_strobe && bus_addr == a, "R3/R11 data clock follows", bus_addr, a);
        bus_rdy = 1'b0;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(!bus_strobe && bus_addr == a && bus_be == be, "R4 wait state", bus_addr, a);
        end
        bus_rdy = 1'b1; bus_narrow = nar; bus_rdata = rd1;
        @(negedge clk);
        bus_rdy = 1'b0;
        if (split) begin
            chk(bus_strobe && bus_addr == a + 32'd2 && bus_be == {be[3:2], 2'b00}, "R9 second half", bus_addr, a + 32'd2);
            chk(bus_wdata == (w ? {16'h0, wd[31:16]} : 32'h0), "R9 upper data low", bus_wdata, w ? {16'h0, wd[31:16]} : 32'h0);
            @(negedge clk);
            bus_rdy = 1'b1; bus_rdata = rd2;
            @(negedge clk);
            bus_rdy = 1'b0;
        end
        chk(!bus_strobe && bus_addr == 32'h0 && !hold_ack, "R5 back to idle", bus_addr, 32'h0);
        bus_narrow = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_strobe && !hold_ack && !rsp_valid && bus_addr == 0 && bus_be == 0 && !bus_wr,
            "R1 reset state", bus_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        xfer(32'h0000_1000, 32'hDEAD_BEEF, 1'b0, 4'hF, 0, 1'b0, 32'h1234_5678, 32'h0);
        xfer(32'h0000_2004, 32'hCAFE_F00D, 1'b1, 4'hF, 3, 1'b0, 32'h0BAD_0001, 32'h0);
        xfer(32'h0000_3000, 32'hA1B2_C3D4, 1'b1, 4'hF, 1, 1'b1, 32'h0000_1111, 32'h0000_2222);
        xfer(32'h0000_4000, 32'h0, 1'b0, 4'hC, 2, 1'b1, 32'hFFFF_AAAA, 32'hEEEE_5555);
        xfer(32'h0000_5000, 32'h0, 1'b0, 4'h3, 0, 1'b1, 32'h7777_8888, 32'h0);

        // Back-to-back cycles (R5).
        put_req(32'h0000_6000, 32'h0, 1'b0, 4'hF);
        exp_q.push_back(32'h6666_0001);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        bus_rdy = 1'b1; bus_rdata = 32'h6666_0001;
        put_req(32'h0000_6100, 32'h0, 1'b0, 4'hF);
        #1;
        chk(req_take == 1'b1, "R5 take at ready", 32'(req_take), 32'h1);
        exp_q.push_back(32'h6666_0002);
        @(negedge clk);
        req_valid = 1'b0; bus_rdy = 1'b0;
        chk(bus_strobe && bus_addr == 32'h0000_6100, "R5 next address clock", bus_addr, 32'h0000_6100);
        @(negedge clk);
        bus_rdy = 1'b1; bus_rdata = 32'h6666_0002;
        @(negedge clk);
        bus_rdy = 1'b0;

        // Hold during a split transfer (R9, R5, R6, R8).
        put_req(32'h0000_7000, 32'h1357_9BDF, 1'b1, 4'hF);
        exp_q.push_back({16'h0B0B, 16'h0A0A});
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        bus_rdy = 1'b1; bus_narrow = 1'b1; hold_req = 1'b1; bus_rdata = 32'h0000_0A0A;
        @(negedge clk);
        bus_rdy = 1'b0; bus_narrow = 1'b0;
        chk(bus_strobe && !hold_ack && bus_addr == 32'h0000_7002, "R9 split before hold", bus_addr, 32'h0000_7002);
        @(negedge clk);
        bus_rdy = 1'b1; bus_rdata = 32'h0000_0B0B;
        @(negedge clk);
        bus_rdy = 1'b0;
        chk(hold_ack && !bus_strobe && bus_addr == 0 && bus_wdata == 0, "R5/R6 hold granted quiet", bus_addr, 32'h0);
        put_req(32'h0000_8000, 32'h0, 1'b0, 4'hF);
        #1;
        chk(req_take == 1'b0, "R8 no take in hold", 32'(req_take), 32'h0);
        @(negedge clk);
        chk(hold_ack == 1'b1, "R8 hold persists", 32'(hold_ack), 32'h1);
        hold_req = 1'b0;
        #1;
        chk(req_take == 1'b1, "R8 take on release", 32'(req_take), 32'h1);
        exp_q.push_back(32'h8888_0000);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_strobe && !hold_ack && bus_addr == 32'h0000_8000, "R8 leave hold to cycle", bus_addr, 32'h0000_8000);
        @(negedge clk);
        bus_rdy = 1'b1; bus_rdata = 32'h8888_0000;
        @(negedge clk);
        bus_rdy = 1'b0;

        // Hold beats a pending request in idle (R7).
        hold_req = 1'b1;
        put_req(32'h0000_9000, 32'h0, 1'b0, 4'hF);
        #1;
        chk(req_take == 1'b0, "R7 hold first", 32'(req_take), 32'h0);
        @(negedge clk);
        chk(hold_ack == 1'b1 && !bus_strobe, "R7 hold entered", 32'(hold_ack), 32'h1);
        hold_req = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(hold_ack == 1'b0 && !bus_strobe, "R8 hold to idle", 32'(hold_ack), 32'h0);

        // Reset in the middle of a cycle (R1).
        put_req(32'h0000_A000, 32'h5555_5555, 1'b1, 4'hF);
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk(!bus_strobe && !bus_wr && bus_addr == 0 && bus_wdata == 0 && !hold_ack, "R1 reset mid cycle", bus_addr, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !bus_strobe, "R10 all responses seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule